// File: doc/BRIEF.md
# Multi-Pin GPIO Interrupt Detector

This block watches a set of seven input pins and folds them into one GPIO interrupt flag for the interrupt controller, which software can also read. Each pin has its own enable and a fixed active polarity. Two pins are active high and the other five are active low. Every pin passes through a two-flop synchroniser before it is evaluated. The flag is a registered output.

A mode bit in the control word picks one of two behaviours. In level mode the flag follows the pins: it is high while any enabled pin sits at its active level. In edge mode a transition towards the active level on any enabled pin latches a request. That request survives the pin going idle again. It is dropped only on reset, by returning to level mode, or by the acknowledge pulse the interrupt controller gives when it enters the service routine. Software has no path to clear it.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, and after reset until a pin condition arises, `irq_flag` is 0. The control word resets to all zeros, so every pin is disabled and the block is in level mode.
- R2: `ctrl[7]` = 0 selects level mode. In this mode `irq_flag` becomes 1 three clock edges after an enabled pin reaches its active level: two synchroniser edges, then the flag register. It returns to 0 three edges after no enabled pin is active any more.
- R3: `ctrl[6:0]` enable pins `pin_raw[6:0]` bit for bit. Pins 5 and 2 are active high. Pins 6, 4, 3, 1 and 0 are active low.
- R4: A pin whose enable bit is 0 never changes `irq_flag`, whatever its level or edges, in either mode.
- R5: `ctrl[7]` = 1 selects edge mode. In this mode a transition of an enabled pin towards its active level sets `irq_flag` three edges after the transition. This is a rising edge for pins 5 and 2 and a falling edge for the others. The flag then stays 1 after the pin goes back to idle.
- R6: In edge mode, a transition of an enabled pin away from its active level does not set `irq_flag`.
- R7: In edge mode, a one-cycle `svc_ack` clears `irq_flag` on the next edge when no new valid edge arrives in that cycle.
- R8: In edge mode, if a valid edge and `svc_ack` fall in the same cycle, the edge wins and `irq_flag` stays 1.
- R9: Writing `ctrl[7]` to 0 makes `irq_flag` equal, on the next edge, to whether any enabled pin is active. This clears a latched edge request when no enabled pin is active.
- R10: In edge mode, enabling a pin that is already resting at its active level does not set `irq_flag`.
- R11: In level mode `svc_ack` has no effect: the flag keeps following the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| pin_raw | input | 7 | Raw asynchronous pin levels |
| ctrl | input | 8 | Control word: bit 7 selects the mode (0 level, 1 edge), bits 6..0 enable the pins |
| svc_ack | input | 1 | One-cycle pulse on entry to the service routine |
| irq_flag | output | 1 | GPIO interrupt flag |

## Verification
The bench builds the block with its default parameters: seven pins, pins 5 and 2 active high, two synchroniser stages and a two-stage reset release. With these values both polarity classes can be driven, in both directions and in both modes. The fixed three-edge latency lets the scoreboard aim each expectation at an exact cycle. The bench also times an acknowledge to land on the same edge as a synchronised pin edge. This reaches the edge-against-acknowledge race, a mode switch while a request is latched, and enabling a pin that already rests at its active level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_EDGE  = 1'b1
  } trig_mode_e;

  localparam int unsigned PIN_COUNT = 7;

  // pins whose active level is high; all others are active low
  localparam logic [PIN_COUNT-1:0] HIGH_ACTIVE_PINS = 7'b0100100;

  // turns a raw level into "asserted" according to the pin polarity
  function automatic logic pin_asserted(input logic level, input logic high_active);
    return high_active ? level : ~level;
  endfunction

endpackage

// File: rtl/gpio_irq_rst_sync.sv
module gpio_irq_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[DEPTH-1];

endmodule

// File: rtl/gpio_irq_pin_sync.sv
module gpio_irq_pin_sync #(
  parameter int unsigned DEPTH    = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_now,
  output logic pin_prev
);

  // DEPTH synchroniser stages followed by one history stage
  localparam int unsigned CHAIN_W = DEPTH + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {CHAIN_W{IDLE_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign pin_now  = chain_q[DEPTH-1];
  assign pin_prev = chain_q[DEPTH];

endmodule

// File: rtl/gpio_irq_pin_eval.sv
module gpio_irq_pin_eval
  import gpio_irq_pkg::*;
#(
  parameter int unsigned        NUM_PINS    = PIN_COUNT,
  parameter logic [NUM_PINS-1:0] ACTIVE_HIGH = HIGH_ACTIVE_PINS
) (
  input  logic [NUM_PINS-1:0] pin_now,
  input  logic [NUM_PINS-1:0] pin_prev,
  input  logic [NUM_PINS-1:0] pin_en,
  output logic [NUM_PINS-1:0] level_hits,
  output logic [NUM_PINS-1:0] edge_hits
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic act_now;
    logic act_prev;

    always_comb begin
      act_now       = pin_asserted(pin_now[i], ACTIVE_HIGH[i]);
      act_prev      = pin_asserted(pin_prev[i], ACTIVE_HIGH[i]);
      level_hits[i] = pin_en[i] & act_now;
      edge_hits[i]  = pin_en[i] & act_now & ~act_prev;
    end
  end

endmodule

// File: rtl/gpio_irq_flag.sv
module gpio_irq_flag
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       level_any,
  input  logic       edge_any,
  input  logic       svc_ack,
  output logic       flag
);

  logic flag_q;
  logic flag_d;
  logic flag_ce;

  always_comb begin
    if (mode == MODE_EDGE) begin
      // a fresh edge wins over a simultaneous acknowledge
      flag_d = edge_any | (flag_q & ~svc_ack);
    end else begin
      flag_d = level_any;
    end
    flag_ce = flag_d ^ flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned         NUM_PINS    = PIN_COUNT,
  parameter logic [NUM_PINS-1:0] ACTIVE_HIGH = HIGH_ACTIVE_PINS,
  parameter int unsigned         SYNC_DEPTH  = 2,
  parameter int unsigned         RST_DEPTH   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS:0]   ctrl,
  input  logic                svc_ack,
  output logic                irq_flag
);

  localparam int unsigned MODE_BIT = NUM_PINS;

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] pin_now;
  logic [NUM_PINS-1:0] pin_prev;
  logic [NUM_PINS-1:0] level_hits;
  logic [NUM_PINS-1:0] edge_hits;
  logic                level_any;
  logic                edge_any;
  trig_mode_e          mode;

  gpio_irq_rst_sync #(.DEPTH(RST_DEPTH)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
    // reset each chain to the pin's idle level so no false edge follows reset
    gpio_irq_pin_sync #(
      .DEPTH    (SYNC_DEPTH),
      .IDLE_VAL (~ACTIVE_HIGH[i])
    ) u_sync (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pin_async (pin_raw[i]),
      .pin_now   (pin_now[i]),
      .pin_prev  (pin_prev[i])
    );
  end

  gpio_irq_pin_eval #(
    .NUM_PINS    (NUM_PINS),
    .ACTIVE_HIGH (ACTIVE_HIGH)
  ) u_eval (
    .pin_now    (pin_now),
    .pin_prev   (pin_prev),
    .pin_en     (ctrl[NUM_PINS-1:0]),
    .level_hits (level_hits),
    .edge_hits  (edge_hits)
  );

  always_comb begin
    level_any = |level_hits;
    edge_any  = |edge_hits;
    mode      = trig_mode_e'(ctrl[MODE_BIT]);
  end

  gpio_irq_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode      (mode),
    .level_any (level_any),
    .edge_any  (edge_any),
    .svc_ack   (svc_ack),
    .flag      (irq_flag)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned NUM_PINS = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [NUM_PINS:0] ctrl,
  input logic              svc_ack,
  input logic              level_any,
  input logic              edge_any,
  input logic              irq_flag
);

  always @(posedge clk) begin
    if (!rst_sync_n) begin
      assert_reset_clear_R1: assert (!irq_flag);
    end
  end

  assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl[NUM_PINS] |=> (irq_flag == $past(level_any)));

  assert_no_cause_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_flag && !level_any && !edge_any) |=> !irq_flag);

  assert_edge_set_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl[NUM_PINS] && edge_any) |=> irq_flag);

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl[NUM_PINS] && irq_flag && !svc_ack) |=> irq_flag);

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl[NUM_PINS] && svc_ack && !edge_any) |=> !irq_flag);

  assert_edge_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl[NUM_PINS] && svc_ack && edge_any) |=> irq_flag);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ctrl       (ctrl),
  .svc_ack    (svc_ack),
  .level_any  (level_any),
  .edge_any   (edge_any),
  .irq_flag   (irq_flag)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

  localparam logic [6:0] PINS_IDLE = 7'b1011011;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [6:0] pins;
  logic [7:0] ctrl;
  logic       ack;
  logic       flag;

  int   cyc;
  int   checks;
  int   errors;
  bit   done;
  exp_t sb_q[$];

  gpio_irq_detect uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pins),
    .ctrl     (ctrl),
    .svc_ack  (ack),
    .irq_flag (flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // queue an expected flag value d edges after the current negedge
  task automatic expect_in(input int d, input logic v, input string tag);
    exp_t e;
    e.cyc = cyc + d;
    e.val = v;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares the flag against due expectations at each negedge
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (flag !== e.val) begin
        errors++;
        $display("FAIL %s cycle %0d: irq_flag=%b expected=%b", e.tag, cyc, flag, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    ctrl   = 8'h00;
    pins   = PINS_IDLE;
    ack    = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    expect_in(1, 1'b0, "R1");
    idle(2);

    // R2, R3: level mode, active-low pin 0
    @(negedge clk); ctrl = 8'h01;
    idle(1);
    @(negedge clk); pins[0] = 1'b0;
    expect_in(2, 1'b0, "R2"); expect_in(3, 1'b1, "R2");
    idle(5);
    @(negedge clk); pins[0] = 1'b1;
    expect_in(2, 1'b1, "R2"); expect_in(3, 1'b0, "R2");
    idle(5);

    // R3: active-high pin 5, active-low pin 4
    @(negedge clk); ctrl = 8'h20; pins[5] = 1'b1;
    expect_in(3, 1'b1, "R3");
    idle(5);
    @(negedge clk); pins[5] = 1'b0;
    expect_in(3, 1'b0, "R3");
    idle(5);
    @(negedge clk); ctrl = 8'h10; pins[4] = 1'b0;
    expect_in(3, 1'b1, "R3");
    idle(5);
    @(negedge clk); pins[4] = 1'b1;
    expect_in(3, 1'b0, "R3");
    idle(5);

    // R4: disabled pin 3 active in level mode
    @(negedge clk); ctrl = 8'h01; pins[3] = 1'b0;
    expect_in(3, 1'b0, "R4"); expect_in(5, 1'b0, "R4");
    idle(6);
    @(negedge clk); pins[3] = 1'b1;
    idle(4);

    // R11: acknowledge in level mode is ignored
    @(negedge clk); pins[0] = 1'b0;
    idle(5);
    @(negedge clk); ack = 1'b1;
    expect_in(1, 1'b1, "R11");
    @(negedge clk); ack = 1'b0;
    expect_in(1, 1'b1, "R11");
    idle(3);
    @(negedge clk); pins[0] = 1'b1;
    idle(5);

    // R5: edge mode, rising edge on pin 2 latches
    @(negedge clk); ctrl = 8'h84;
    idle(3);
    @(negedge clk); pins[2] = 1'b1;
    expect_in(2, 1'b0, "R5"); expect_in(3, 1'b1, "R5");
    idle(5);
    @(negedge clk); pins[2] = 1'b0;
    expect_in(3, 1'b1, "R5"); expect_in(6, 1'b1, "R5");
    idle(8);

    // R7: acknowledge clears
    @(negedge clk); ack = 1'b1;
    expect_in(1, 1'b0, "R7");
    @(negedge clk); ack = 1'b0;
    expect_in(2, 1'b0, "R7");
    idle(4);

    // R6: falling edge on pin 3 sets, rising edge does not
    @(negedge clk); ctrl = 8'h88;
    idle(3);
    @(negedge clk); pins[3] = 1'b0;
    expect_in(3, 1'b1, "R5");
    idle(5);
    @(negedge clk); ack = 1'b1;
    expect_in(1, 1'b0, "R7");
    @(negedge clk); ack = 1'b0;
    idle(3);
    @(negedge clk); pins[3] = 1'b1;
    expect_in(3, 1'b0, "R6"); expect_in(5, 1'b0, "R6");
    idle(6);

    // R4: falling edge on disabled pin 1 in edge mode
    @(negedge clk); pins[1] = 1'b0;
    expect_in(3, 1'b0, "R4"); expect_in(5, 1'b0, "R4");
    idle(6);

    // R10: enabling pin 1 while it already rests active
    @(negedge clk); ctrl = 8'h82;
    expect_in(1, 1'b0, "R10"); expect_in(4, 1'b0, "R10");
    idle(6);
    @(negedge clk); pins[1] = 1'b1;
    idle(5);
    @(negedge clk); pins[1] = 1'b0;
    expect_in(3, 1'b1, "R5");
    idle(5);
    @(negedge clk); ack = 1'b1;
    expect_in(1, 1'b0, "R7");
    @(negedge clk); ack = 1'b0;
    idle(3);

    // R8: edge and acknowledge on the same edge, flag already set
    @(negedge clk); ctrl = 8'h84;
    idle(3);
    @(negedge clk); pins[2] = 1'b1;
    expect_in(3, 1'b1, "R5");
    idle(5);
    @(negedge clk); pins[2] = 1'b0;
    idle(5);
    @(negedge clk); pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); ack = 1'b1;
    expect_in(1, 1'b1, "R8");
    @(negedge clk); ack = 1'b0;
    expect_in(1, 1'b1, "R8");
    idle(3);

    // R9: switch to level mode clears a latched request
    @(negedge clk); ctrl = 8'h01;
    expect_in(1, 1'b0, "R9");
    idle(3);
    @(negedge clk); ctrl = 8'h84; pins[2] = 1'b0;
    idle(4);
    @(negedge clk); pins[2] = 1'b1;
    expect_in(3, 1'b1, "R5");
    idle(5);
    @(negedge clk); ctrl = 8'h04;
    expect_in(1, 1'b1, "R9");
    idle(2);
    @(negedge clk); ctrl = 8'h01;
    expect_in(1, 1'b0, "R9");
    idle(3);

    while (sb_q.size() > 0) @(negedge clk);
    idle(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule